// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches one external input pin and, when a qualifying event occurs on it, copies the current value of a free-running timer into a capture register in a single clock cycle. A 4-bit mode field chooses what counts as an event. The choices are every falling edge, every rising edge, every fourth rising edge, or every sixteenth rising edge. Any other mode value leaves the unit idle. Each capture raises a sticky interrupt request, which stays up until software pulses a clear strobe.

The pin is asynchronous. It passes through a synchronizer before edge detection, so a capture lands a fixed number of clock cycles after the pin moves. When the pin is configured as an output, the value written to the pin data bit replaces the external level at the detector. Such a write can therefore cause a capture.

Two behaviours are deliberate:

- The prescale counter is cleared only while the unit is not in a capture mode. A direct switch between the divide-by-4 and divide-by-16 settings keeps the partial count.
- Any mode write that changes the field to a capture mode raises the interrupt flag, even though no capture took place.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset the capture register reads 0, the interrupt output is 0, the mode is 0000 (off) and the prescale count is 0.
- R2: In mode 0100 every falling edge of the pin source captures and rising edges do nothing. The capture register and interrupt change at the third rising clock edge after the pin level is first sampled at a new value.
- R3: In mode 0101 every rising edge of the pin source captures and falling edges do nothing, with the same three-cycle latency.
- R4: In mode 0110 every 4th rising edge captures, and in mode 0111 every 16th rising edge captures. The count restarts at zero after each capture.
- R5: Any mode value other than 0100, 0101, 0110 and 0111, including 0000 and 1000, never captures and forces the prescale count to zero. A later capture mode therefore starts counting from zero.
- R6: The interrupt output stays 1 until a cycle with flag_clr high and no set condition. A set condition and flag_clr in the same cycle leave it at 1.
- R7: A capture overwrites the capture register whether or not the previous value was read or the flag cleared.
- R8: Switching directly between 0110 and 0111 keeps the prescale count. After two rising edges in 0110 and a switch to 0111, the 14th following rising edge captures.
- R9: A mode write whose new value differs from the current mode and is a capture mode sets the interrupt flag. A write of the same value, or of a non-capture value, does not.
- R10: While pin_is_output is 1, the detector sees pin_out_data instead of pin_async, so edges on pin_out_data can capture and edges on pin_async are ignored.
- R11: A capture stores all 16 bits of timer_val, as presented at the capture clock edge, in that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | TMR_W (16) | Free-running timer value |
| pin_async | input | 1 | External pin level, asynchronous |
| pin_is_output | input | 1 | 1 when the pin is configured as an output |
| pin_out_data | input | 1 | Pin data bit used when the pin is an output |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode value to write |
| flag_clr | input | 1 | Clear strobe for the interrupt flag |
| cap_val | output | TMR_W (16) | Capture register read port |
| irq | output | 1 | Interrupt request flag |

## Verification
Three kinds of internal error reach the ports directly.

- A prescale count that is wrong, or was not cleared, moves a capture earlier or later by whole pin edges. It shows up as irq rising on the wrong pulse and cap_val holding a timer value from a different edge.
- A synchronizer or edge detector with the wrong depth moves the capture by whole clock cycles. cap_val is then off by the timer's step count within three cycles of the pin moving.
- A wrong mode register or flag shows at once as an irq level that differs in the cycle after a write or a clear strobe.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   typedef enum logic [3:0] {
      TCAP_OFF   = 4'b0000,
      TCAP_FALL  = 4'b0100,
      TCAP_RISE  = 4'b0101,
      TCAP_DIVLO = 4'b0110,
      TCAP_DIVHI = 4'b0111
   } tcap_mode_e;

   localparam int unsigned TCAP_MODE_W = 4;

   // capture modes occupy the 01xx group
   function automatic logic tcap_is_capture(input logic [TCAP_MODE_W-1:0] m);
      return (m[3:2] == 2'b01);
   endfunction

   function automatic logic tcap_is_divided(input logic [TCAP_MODE_W-1:0] m);
      return (m[3:1] == 3'b011);
   endfunction

endpackage

// File: rtl/tcap_pin_sync.sv
module tcap_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tcap_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise =  chain[STAGES-1] & ~last_q;
   assign fall = ~chain[STAGES-1] &  last_q;

endmodule

// File: rtl/tcap_edge_qual.sv
module tcap_edge_qual
   import tcap_pkg::*;
#(
   parameter int unsigned DIV_LO = 4,
   parameter int unsigned DIV_HI = 16,
   parameter int unsigned PS_W   = $clog2(DIV_HI)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TCAP_MODE_W-1:0] mode,
   input  logic                   rise,
   input  logic                   fall,
   output logic                   cap_evt,
   output logic [PS_W-1:0]        cnt
);

   if (DIV_LO < 2 || DIV_HI < DIV_LO) begin : g_bad_div
      $error("tcap_edge_qual: need 2 <= DIV_LO <= DIV_HI");
   end
   if ((1 << PS_W) < DIV_HI) begin : g_bad_psw
      $error("tcap_edge_qual: PS_W too narrow for DIV_HI");
   end

   localparam logic [PS_W:0] LIM_LO = (PS_W+1)'(DIV_LO);
   localparam logic [PS_W:0] LIM_HI = (PS_W+1)'(DIV_HI);

   logic [PS_W-1:0] cnt_q, cnt_d;
   logic [PS_W:0]   cnt_inc;
   logic [PS_W:0]   limit;
   logic            evt;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign limit   = (mode == TCAP_DIVHI) ? LIM_HI : LIM_LO;

   always_comb begin
      evt   = 1'b0;
      cnt_d = cnt_q;
      if (!tcap_is_capture(mode)) begin
         cnt_d = '0;
      end else if (tcap_is_divided(mode)) begin
         if (rise) begin
            if (cnt_inc >= limit) begin
               evt   = 1'b1;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_inc[PS_W-1:0];
            end
         end
      end else if (mode == TCAP_FALL) begin
         evt = fall;
      end else begin
         evt = rise;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cap_evt = evt;
   assign cnt     = cnt_q;

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
   import tcap_pkg::*;
#(
   parameter int unsigned TMR_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_LO      = 4,
   parameter int unsigned DIV_HI      = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TMR_W-1:0]       timer_val,
   input  logic                   pin_async,
   input  logic                   pin_is_output,
   input  logic                   pin_out_data,
   input  logic                   mode_wr,
   input  logic [TCAP_MODE_W-1:0] mode_wdata,
   input  logic                   flag_clr,
   output logic [TMR_W-1:0]       cap_val,
   output logic                   irq
);

   localparam int unsigned PS_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

   if (TMR_W < 2) begin : g_bad_width
      $error("tmr_capture_unit: TMR_W must be at least 2");
   end

   logic                   pin_src;
   logic                   rise, fall;
   logic                   cap_evt;
   logic [PS_W-1:0]        ps_cnt;
   logic [TCAP_MODE_W-1:0] mode_q;
   logic                   spur_set;
   logic [TMR_W-1:0]       cap_q;
   logic                   irq_q;

   // output-configured pin feeds its own data bit back to the detector
   assign pin_src = pin_is_output ? pin_out_data : pin_async;

   tcap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_src),
      .rise   (rise),
      .fall   (fall)
   );

   tcap_edge_qual #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .PS_W(PS_W)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .rise    (rise),
      .fall    (fall),
      .cap_evt (cap_evt),
      .cnt     (ps_cnt)
   );

   assign spur_set = mode_wr && (mode_wdata != mode_q) && tcap_is_capture(mode_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= TCAP_OFF;
      else if (mode_wr) mode_q <= mode_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_q <= '0;
      else if (cap_evt) cap_q <= timer_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    irq_q <= 1'b0;
      else if (cap_evt || spur_set)  irq_q <= 1'b1;
      else if (flag_clr)             irq_q <= 1'b0;
   end

   assign cap_val = cap_q;
   assign irq     = irq_q;

endmodule

// File: rtl/tcap_checker.sv
module tcap_checker
   import tcap_pkg::*;
#(
   parameter int unsigned TMR_W = 16,
   parameter int unsigned PS_W  = 4,
   parameter int unsigned DIV_HI = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   irq,
   input logic                   flag_clr,
   input logic                   cap_evt,
   input logic                   spur_set,
   input logic [TMR_W-1:0]       cap_val,
   input logic [TMR_W-1:0]       timer_val,
   input logic [TCAP_MODE_W-1:0] mode_q,
   input logic [PS_W-1:0]        ps_cnt
);

   p_evt_sets_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> irq);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !flag_clr) |=> irq);

   p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !cap_evt && !spur_set) |=> !irq);

   p_cap_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_val == $past(timer_val)));

   p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt |=> $stable(cap_val));

   p_idle_no_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tcap_is_capture(mode_q) |-> !cap_evt);

   p_idle_cnt_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tcap_is_capture(mode_q) |=> (ps_cnt == '0));

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(ps_cnt) < DIV_HI));

endmodule

bind tmr_capture_unit tcap_checker #(.TMR_W(TMR_W), .PS_W(PS_W), .DIV_HI(DIV_HI)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .flag_clr  (flag_clr),
   .cap_evt   (cap_evt),
   .spur_set  (spur_set),
   .cap_val   (cap_val),
   .timer_val (timer_val),
   .mode_q    (mode_q),
   .ps_cnt    (ps_cnt)
);

// File: tb/tb_tmr_capture_unit.sv
module tb_tmr_capture_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] timer_val = 16'h1200;
   logic        pin_async = 1'b0;
   logic        pin_is_output = 1'b0;
   logic        pin_out_data = 1'b0;
   logic        mode_wr = 1'b0;
   logic [3:0]  mode_wdata = 4'b0000;
   logic        flag_clr = 1'b0;
   logic [15:0] cap_val;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit cmp_on = 0;
   logic [15:0] lt;

   always #5 clk = ~clk;

   tmr_capture_unit dut (
      .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
      .pin_async(pin_async), .pin_is_output(pin_is_output),
      .pin_out_data(pin_out_data), .mode_wr(mode_wr),
      .mode_wdata(mode_wdata), .flag_clr(flag_clr),
      .cap_val(cap_val), .irq(irq)
   );

   // free-running timer with an odd step
   always @(posedge clk) timer_val <= timer_val + 16'd3;

   // behavioural reference model
   bit          hist[$] = '{0, 0, 0, 0};
   int          m_mode = 0;
   int          m_cnt  = 0;
   logic [15:0] m_cap  = '0;
   bit          m_flag = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{0, 0, 0, 0};
         m_mode = 0; m_cnt = 0; m_cap = '0; m_flag = 0;
      end else begin
         bit src, nw, od, ev, spur, iscap;
         int div;
         src = pin_is_output ? pin_out_data : pin_async;
         hist.push_back(src);
         void'(hist.pop_front());
         od = hist[0];
         nw = hist[1];
         ev = 0;
         iscap = (m_mode >= 4 && m_mode <= 7);
         if (m_mode == 4) ev = od && !nw;
         else if (m_mode == 5) ev = nw && !od;
         else if (m_mode == 6 || m_mode == 7) begin
            div = (m_mode == 6) ? 4 : 16;
            if (nw && !od) begin
               if (m_cnt + 1 >= div) begin ev = 1; m_cnt = 0; end
               else m_cnt = m_cnt + 1;
            end
         end
         if (!iscap) m_cnt = 0;
         spur = mode_wr && (int'(mode_wdata) != m_mode) &&
                (mode_wdata >= 4 && mode_wdata <= 7);
         if (ev) m_cap = timer_val;
         if (ev || spur) m_flag = 1;
         else if (flag_clr) m_flag = 0;
         if (mode_wr) m_mode = int'(mode_wdata);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model (R11 capture value, R6 flag)
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk(cap_val === m_cap, "R11 model cap_val", int'(cap_val), int'(m_cap));
         chk(irq === m_flag, "R6 model irq", int'(irq), int'(m_flag));
      end
   end

   task automatic wr_mode(input logic [3:0] v);
      @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic clr();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   // one rising then falling transition; lt gets the expected capture value of the rise
   task automatic pulse(input bit loopback);
      @(negedge clk);
      if (loopback) pin_out_data = 1'b1; else pin_async = 1'b1;
      lt = timer_val + 16'd6;
      repeat (2) @(negedge clk);
      if (loopback) pin_out_data = 1'b0; else pin_async = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) pulse(1'b0);
   endtask

   initial begin
      logic [15:0] t0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cap_val == 16'h0, "R1 reset cap_val", int'(cap_val), 0);
      chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
      rst_n = 1'b1;
      cmp_on = 1;

      // R9 spurious flag on change into a capture mode
      wr_mode(4'b0100);
      chk(irq == 1'b1, "R9 spurious flag", int'(irq), 1);
      clr();
      chk(irq == 1'b0, "R6 clear", int'(irq), 0);

      // R2 falling-edge mode
      @(negedge clk); pin_async = 1'b1;
      repeat (4) @(negedge clk);
      chk(irq == 1'b0, "R2 rise ignored", int'(irq), 0);
      pin_async = 1'b0; t0 = timer_val + 16'd6;
      repeat (2) @(negedge clk);
      chk(irq == 1'b0, "R2 latency not early", int'(irq), 0);
      @(negedge clk);
      chk(irq == 1'b1, "R2 capture flag", int'(irq), 1);
      chk(cap_val == t0, "R11 capture value", int'(cap_val), int'(t0));
      repeat (5) @(negedge clk);
      chk(irq == 1'b1, "R6 sticky", int'(irq), 1);

      // R3 rising-edge mode with set/clear collision
      clr(); wr_mode(4'b0101); clr();
      @(negedge clk); pin_async = 1'b1; t0 = timer_val + 16'd6;
      @(negedge clk);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      chk(irq == 1'b1, "R6 set beats clear", int'(irq), 1);
      chk(cap_val == t0, "R3 rising capture", int'(cap_val), int'(t0));
      pin_async = 1'b0;
      repeat (4) @(negedge clk);
      chk(cap_val == t0, "R3 fall ignored", int'(cap_val), int'(t0));

      // R7 overwrite with flag still set
      pulse(1'b0);
      pulse(1'b0);
      chk(cap_val == lt, "R7 overwrite", int'(cap_val), int'(lt));

      // R4 divide by 4
      clr(); wr_mode(4'b0110); clr();
      pulses(3);
      chk(irq == 1'b0, "R4 div4 no early", int'(irq), 0);
      pulse(1'b0);
      chk(irq == 1'b1, "R4 div4 fourth", int'(irq), 1);
      chk(cap_val == lt, "R4 div4 value", int'(cap_val), int'(lt));
      clr();
      wr_mode(4'b0110);
      chk(irq == 1'b0, "R9 same value no flag", int'(irq), 0);

      // R8 count kept across prescale switch
      pulses(2);
      wr_mode(4'b0111);
      chk(irq == 1'b1, "R9 switch flag", int'(irq), 1);
      clr();
      pulses(13);
      chk(irq == 1'b0, "R8 no capture at 13", int'(irq), 0);
      pulse(1'b0);
      chk(irq == 1'b1, "R8 early capture at 14", int'(irq), 1);
      chk(cap_val == lt, "R8 value", int'(cap_val), int'(lt));
      clr();

      // R5 off clears count
      pulses(3);
      wr_mode(4'b0000);
      chk(irq == 1'b0, "R9 off no flag", int'(irq), 0);
      pulses(3);
      chk(irq == 1'b0, "R5 off no capture", int'(irq), 0);
      wr_mode(4'b1000);
      pulses(2);
      chk(irq == 1'b0, "R5 1000 no capture", int'(irq), 0);
      wr_mode(4'b0110); clr();
      pulses(3);
      chk(irq == 1'b0, "R5 count restarted", int'(irq), 0);
      pulse(1'b0);
      chk(irq == 1'b1, "R5 capture at fourth", int'(irq), 1);

      // R10 loopback
      clr(); wr_mode(4'b0101); clr();
      @(negedge clk); pin_is_output = 1'b1;
      repeat (4) @(negedge clk);
      t0 = cap_val;
      pulse(1'b0);
      chk(irq == 1'b0, "R10 external ignored", int'(irq), 0);
      chk(cap_val == t0, "R10 external no load", int'(cap_val), int'(t0));
      pulse(1'b1);
      chk(irq == 1'b1, "R10 loopback capture", int'(irq), 1);
      chk(cap_val == lt, "R10 loopback value", int'(cap_val), int'(lt));
      @(negedge clk); pin_is_output = 1'b0;
      repeat (4) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule